// File: doc/BRIEF.md
# SPI Serial Flash Command Front End

This block is the device side of a serial flash interface. It watches the serial clock, chip select and serial data input, all of them already synchronous to the system clock `clk`. It assembles command bytes and works out from the opcode how many address, dummy and data bytes follow. It then either streams data back on the serial output or, when chip select rises on a legal frame boundary, issues one abstract request to the backing array. A request is a byte program, one of three erase sizes, a chip erase or a status write. Array reads go through a combinational memory port: the block presents an address and takes the byte back in the same cycle.

A write-enable latch guards every command that changes the array or the status. Status, manufacturer/device ID and the three-byte JEDEC-style identity come from internal registers and parameters.

Requests leave the block on a valid/ready channel. Once `req_valid` is high, kind, address and data stay stable until the cycle in which `req_ready` is also high. That cycle is the acceptance, and `req_valid` falls after it. While a request is waiting, any further modifying command is dropped, and the status busy bit reads 1. This gives software a way to poll for back-pressure.

Top module: `spi_flash_frontend`

## Requirements
- R1: After reset `so_oe` and `req_valid` are 0, and a status read returns 8'h00.
- R2: Bits are sampled on the rising SCK edge, MSB first. Output bits change after a falling SCK edge, MSB first. Opcode 8'h03 with three address bytes streams array bytes from that address, incrementing, until chip select rises, and `so_oe` is 1 while it streams.
- R3: Opcode 8'h0B takes three address bytes and one dummy byte, then streams like R2.
- R4: Opcode 8'h05 streams the status byte repeatedly. Bit 1 is the write-enable latch. Bit 0 is busy, meaning a request is waiting for acceptance. Bits 7:2 are the user status bits.
- R5: Opcode 8'h06 sets the latch and 8'h04 clears it. Program, erase and status-write frames completed while the latch is clear issue no request.
- R6: Erase opcodes map to these request kinds:
  - 8'h20 gives kind 1 with address bits 11:0 cleared.
  - 8'h52 gives kind 2 with bits 14:0 cleared.
  - 8'hD8 gives kind 3 with bits 15:0 cleared.
  - 8'h60 and 8'hC7 give kind 4 with address 0.
- R7: Opcode 8'h02 with three address bytes and one data byte issues kind 0 carrying that address and data.
- R8: Chip select rising mid-byte, or after too few or too many bytes for the opcode, cancels the command with no request and no latch change.
- R9: Opcodes 8'h90 and 8'hAB take three address bytes. They return the manufacturer ID (8'h5E) when address bit 0 is 0, or the device ID (8'h91) when it is 1, then alternate between the two. Opcode 8'h9F returns 8'h5E, 8'h26, 8'h82, repeating.
- R10: An unknown opcode leaves `so_oe` at 0 until chip select rises.
- R11: A waiting request holds kind, address and data stable until accepted. The latch clears on acceptance, and a modifying command completed while a request waits is dropped.
- R12: Opcode 8'h01 with one data byte issues kind 5 with that data and loads status bits 7:2 from data bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so_data | output | 1 | Serial data out |
| so_oe | output | 1 | Serial output enable (0 = high impedance) |
| req_valid | output | 1 | Array request valid |
| req_ready | input | 1 | Array request ready |
| req_kind | output | 3 | Request kind code (R6, R7, R12) |
| req_addr | output | ADDR_BYTES*8 | Request address |
| req_data | output | 8 | Program or status data |
| mem_raddr | output | ADDR_BYTES*8 | Array read address |
| mem_rdata | input | 8 | Array read data, combinational |

## Verification
The bench targets frames that end at the wrong moment. These are frames cut short mid-byte, erase frames missing an address byte, and chip erase followed by a stray byte. A decoder that acts on the opcode alone, rather than on the boundary, would issue a request there. It also holds the ready signal low across a second program. A design without the busy gate would overwrite or duplicate the waiting request, and one that clears the latch at issue time rather than acceptance would show the wrong status. Erase address masking, the dummy byte of the fast read and the ID alternation phase are each checked byte for byte, because an off-by-one in any of them shifts the output stream.

// File: rtl/spi_flash_pkg.sv
`timescale 1ns/1ps
package spi_flash_pkg;

  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_FAST   = 8'h0B;
  localparam logic [7:0] OPC_ER4K   = 8'h20;
  localparam logic [7:0] OPC_ER32K  = 8'h52;
  localparam logic [7:0] OPC_ER64K  = 8'hD8;
  localparam logic [7:0] OPC_CHIP_A = 8'h60;
  localparam logic [7:0] OPC_CHIP_B = 8'hC7;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_WRST   = 8'h01;
  localparam logic [7:0] OPC_RDST   = 8'h05;
  localparam logic [7:0] OPC_WEN    = 8'h06;
  localparam logic [7:0] OPC_WDIS   = 8'h04;
  localparam logic [7:0] OPC_ID_A   = 8'h90;
  localparam logic [7:0] OPC_ID_B   = 8'hAB;
  localparam logic [7:0] OPC_JID    = 8'h9F;

  typedef enum logic [2:0] {
    REQ_PROG  = 3'd0,
    REQ_ER4K  = 3'd1,
    REQ_ER32K = 3'd2,
    REQ_ER64K = 3'd3,
    REQ_CHIP  = 3'd4,
    REQ_WRST  = 3'd5
  } req_kind_e;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_DUMMY,
    PH_DIN,
    PH_TAIL,
    PH_STREAM,
    PH_IGNORE
  } phase_e;

endpackage

// File: rtl/spi_bit_shifter.sv
`timescale 1ns/1ps
module spi_bit_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  input  logic       stream_en,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] byte_in,
  output logic       at_boundary,
  output logic       cs_rise,
  output logic       tx_take,
  output logic       so_data,
  output logic       so_oe
);
  logic       sck_q, csn_q;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] txreg;
  logic       sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck;
      csn_q <= cs_n;
    end
  end

  assign sck_rise    = sck & ~sck_q;
  assign sck_fall    = ~sck & sck_q;
  assign cs_rise     = cs_n & ~csn_q;
  assign at_boundary = (bitcnt == 3'd0);
  assign byte_done   = sck_rise & ~cs_n & (bitcnt == 3'd7);
  assign byte_in     = {shreg, si};
  assign tx_take     = sck_fall & ~cs_n & at_boundary & stream_en;
  assign so_data     = txreg[7];

  // receive side: one bit per rising edge, wraps every eight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      shreg  <= '0;
    end else if (cs_n) begin
      bitcnt <= '0;
    end else if (sck_rise) begin
      shreg  <= {shreg[5:0], si};
      bitcnt <= bitcnt + 3'd1;
    end
  end

  // transmit side: new byte on the falling edge at a byte boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreg <= '0;
      so_oe <= 1'b0;
    end else if (cs_n) begin
      txreg <= '0;
      so_oe <= 1'b0;
    end else if (tx_take) begin
      txreg <= tx_byte;
      so_oe <= 1'b1;
    end else if (sck_fall) begin
      txreg <= {txreg[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
`timescale 1ns/1ps
module spi_cmd_decoder
  import spi_flash_pkg::*;
#(
  parameter int         ADDR_BYTES = 3,
  parameter int         SECT_LSB   = 12,
  parameter int         BLKS_LSB   = 15,
  parameter int         BLKL_LSB   = 16,
  parameter logic [7:0] MFG_ID     = 8'h5E,
  parameter logic [7:0] DEV_ID     = 8'h91,
  parameter logic [7:0] JID_TYPE   = 8'h26,
  parameter logic [7:0] JID_CAP    = 8'h82,
  localparam int        ADDR_W     = ADDR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              byte_done,
  input  logic [7:0]        byte_in,
  input  logic              at_boundary,
  input  logic              cs_rise,
  input  logic              tx_take,
  input  logic              req_busy,
  input  logic              req_accept,
  input  logic [7:0]        mem_rdata,
  output logic              stream_en,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              issue,
  output req_kind_e         iss_kind,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [7:0]        iss_data,
  output logic              wel
);
  localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  phase_e            phase;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addr;
  logic [ACW-1:0]    acnt;
  logic [7:0]        dat;
  logic              armed;
  logic [1:0]        idx;
  logic [5:0]        st_user;
  logic              modify_op;
  logic              frame_ok;

  assign stream_en = (phase == PH_STREAM);
  assign mem_raddr = addr;
  assign iss_data  = dat;
  assign frame_ok  = cs_rise & armed & at_boundary;
  assign issue     = frame_ok & modify_op & wel & ~req_busy;

  always_comb begin
    modify_op = 1'b1;
    iss_kind  = REQ_PROG;
    iss_addr  = addr;
    case (opcode)
      OPC_PROG: ;
      OPC_ER4K: begin
        iss_kind = REQ_ER4K;
        iss_addr = {addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
      end
      OPC_ER32K: begin
        iss_kind = REQ_ER32K;
        iss_addr = {addr[ADDR_W-1:BLKS_LSB], {BLKS_LSB{1'b0}}};
      end
      OPC_ER64K: begin
        iss_kind = REQ_ER64K;
        iss_addr = {addr[ADDR_W-1:BLKL_LSB], {BLKL_LSB{1'b0}}};
      end
      OPC_CHIP_A, OPC_CHIP_B: begin
        iss_kind = REQ_CHIP;
        iss_addr = '0;
      end
      OPC_WRST: begin
        iss_kind = REQ_WRST;
        iss_addr = '0;
      end
      default: modify_op = 1'b0;
    endcase
  end

  always_comb begin
    case (opcode)
      OPC_READ, OPC_FAST:   tx_byte = mem_rdata;
      OPC_RDST:             tx_byte = {st_user, wel, req_busy};
      OPC_ID_A, OPC_ID_B:   tx_byte = idx[0] ? DEV_ID : MFG_ID;
      OPC_JID: begin
        case (idx)
          2'd0:    tx_byte = MFG_ID;
          2'd1:    tx_byte = JID_TYPE;
          default: tx_byte = JID_CAP;
        endcase
      end
      default:              tx_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_OPCODE;
      opcode  <= '0;
      addr    <= '0;
      acnt    <= '0;
      dat     <= '0;
      armed   <= 1'b0;
      idx     <= '0;
      wel     <= 1'b0;
      st_user <= '0;
    end else begin
      if (req_accept) wel <= 1'b0;
      if (cs_n) begin
        phase <= PH_OPCODE;
        armed <= 1'b0;
        acnt  <= '0;
        if (frame_ok) begin
          case (opcode)
            OPC_WEN:  wel <= 1'b1;
            OPC_WDIS: wel <= 1'b0;
            OPC_WRST: if (issue) st_user <= dat[7:2];
            default: ;
          endcase
        end
      end else if (byte_done) begin
        case (phase)
          PH_OPCODE: begin
            opcode <= byte_in;
            idx    <= '0;
            case (byte_in)
              OPC_READ, OPC_FAST, OPC_ER4K, OPC_ER32K, OPC_ER64K,
              OPC_PROG, OPC_ID_A, OPC_ID_B:
                phase <= PH_ADDR;
              OPC_CHIP_A, OPC_CHIP_B, OPC_WEN, OPC_WDIS: begin
                phase <= PH_TAIL;
                armed <= 1'b1;
              end
              OPC_WRST:          phase <= PH_DIN;
              OPC_RDST, OPC_JID: phase <= PH_STREAM;
              default:           phase <= PH_IGNORE;
            endcase
          end
          PH_ADDR: begin
            addr <= {addr[ADDR_W-9:0], byte_in};
            acnt <= acnt + 1'b1;
            if (acnt == ACW'(ADDR_BYTES - 1)) begin
              case (opcode)
                OPC_READ: phase <= PH_STREAM;
                OPC_FAST: phase <= PH_DUMMY;
                OPC_PROG: phase <= PH_DIN;
                OPC_ID_A, OPC_ID_B: begin
                  phase <= PH_STREAM;
                  idx   <= {1'b0, byte_in[0]};
                end
                default: begin
                  phase <= PH_TAIL;
                  armed <= 1'b1;
                end
              endcase
            end
          end
          PH_DUMMY: phase <= PH_STREAM;
          PH_DIN: begin
            dat   <= byte_in;
            armed <= 1'b1;
            phase <= PH_TAIL;
          end
          PH_TAIL: begin
            armed <= 1'b0;
            phase <= PH_IGNORE;
          end
          default: ;
        endcase
      end else if (tx_take) begin
        case (opcode)
          OPC_READ, OPC_FAST:  addr <= addr + 1'b1;
          OPC_ID_A, OPC_ID_B:  idx  <= idx ^ 2'd1;
          OPC_JID:             idx  <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_req_hold.sv
`timescale 1ns/1ps
module spi_req_hold
  import spi_flash_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  req_kind_e         iss_kind,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [7:0]        iss_data,
  input  logic              ready,
  output logic              valid,
  output req_kind_e         kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [7:0]        data_q,
  output logic              accept
);
  assign accept = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      kind_q <= REQ_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else if (issue && !valid) begin
      valid  <= 1'b1;
      kind_q <= iss_kind;
      addr_q <= iss_addr;
      data_q <= iss_data;
    end else if (accept) begin
      valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_flash_frontend.sv
`timescale 1ns/1ps
module spi_flash_frontend
  import spi_flash_pkg::*;
#(
  parameter int         ADDR_BYTES = 3,
  parameter int         SECT_LSB   = 12,
  parameter int         BLKS_LSB   = 15,
  parameter int         BLKL_LSB   = 16,
  parameter logic [7:0] MFG_ID     = 8'h5E,
  parameter logic [7:0] DEV_ID     = 8'h91,
  parameter logic [7:0] JID_TYPE   = 8'h26,
  parameter logic [7:0] JID_CAP    = 8'h82,
  localparam int        ADDR_W     = ADDR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so_data,
  output logic              so_oe,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata
);
  logic              byte_done, at_boundary, cs_rise, tx_take, stream_en;
  logic [7:0]        byte_in, tx_byte, iss_data;
  logic              issue, req_accept, wel;
  req_kind_e         iss_kind, kind_q;
  logic [ADDR_W-1:0] iss_addr;

  assign req_kind = kind_q;

  spi_bit_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .stream_en(stream_en), .tx_byte(tx_byte),
    .byte_done(byte_done), .byte_in(byte_in), .at_boundary(at_boundary),
    .cs_rise(cs_rise), .tx_take(tx_take), .so_data(so_data), .so_oe(so_oe)
  );

  spi_cmd_decoder #(
    .ADDR_BYTES(ADDR_BYTES), .SECT_LSB(SECT_LSB), .BLKS_LSB(BLKS_LSB),
    .BLKL_LSB(BLKL_LSB), .MFG_ID(MFG_ID), .DEV_ID(DEV_ID),
    .JID_TYPE(JID_TYPE), .JID_CAP(JID_CAP)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_done(byte_done),
    .byte_in(byte_in), .at_boundary(at_boundary), .cs_rise(cs_rise),
    .tx_take(tx_take), .req_busy(req_valid), .req_accept(req_accept),
    .mem_rdata(mem_rdata), .stream_en(stream_en), .tx_byte(tx_byte),
    .mem_raddr(mem_raddr), .issue(issue), .iss_kind(iss_kind),
    .iss_addr(iss_addr), .iss_data(iss_data), .wel(wel)
  );

  spi_req_hold #(.ADDR_W(ADDR_W)) u_req (
    .clk(clk), .rst_n(rst_n), .issue(issue), .iss_kind(iss_kind),
    .iss_addr(iss_addr), .iss_data(iss_data), .ready(req_ready),
    .valid(req_valid), .kind_q(kind_q), .addr_q(req_addr),
    .data_q(req_data), .accept(req_accept)
  );
endmodule

// File: rtl/spi_flash_frontend_chk.sv
`timescale 1ns/1ps
module spi_flash_frontend_chk #(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              so_oe,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_data,
  input logic              wel
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_kind) && $stable(req_data)); // R11

  AST_ISSUE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(wel)); // R5

  AST_ISSUE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(cs_n)); // R8

  AST_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 3'd1 |-> req_addr[SECT_LSB-1:0] == '0); // R6

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> !so_oe); // R10

  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && cs_n |=> !wel); // R11
endmodule

bind spi_flash_frontend spi_flash_frontend_chk #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .req_valid(req_valid),
  .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
  .req_data(req_data), .wel(wel)
);

// File: tb/sim_spi_flash_frontend.sv
`timescale 1ns/1ps
module sim_spi_flash_frontend;
  logic        clk = 1'b0;
  logic        rst_n, sck, cs_n, si, rdy;
  logic        so_data, so_oe, req_valid;
  logic [2:0]  req_kind;
  logic [23:0] req_addr, mem_raddr;
  logic [7:0]  req_data, mem_rdata;

  int n_chk = 0, n_bad = 0, n_acc = 0;
  logic [2:0]  acc_kind;
  logic [23:0] acc_addr;
  logic [7:0]  acc_data;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memv(logic [23:0] a);
    return a[7:0] * 8'd7 + 8'd3;
  endfunction
  assign mem_rdata = memv(mem_raddr);

  spi_flash_frontend u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so_data(so_data), .so_oe(so_oe), .req_valid(req_valid), .req_ready(rdy),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (rst_n && req_valid && rdy) begin
      n_acc    <= n_acc + 1;
      acc_kind <= req_kind;
      acc_addr <= req_addr;
      acc_data <= req_data;
    end
  end

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fbegin();
    wclk(1); cs_n = 1'b0; wclk(4);
  endtask

  task automatic fend();
    wclk(4); cs_n = 1'b1; wclk(8);
  endtask

  task automatic xbit(logic b, output logic o);
    si = b; wclk(4); o = so_data; sck = 1'b1; wclk(4); sck = 1'b0;
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    logic o;
    for (int i = 7; i > 7 - n; i--) xbit(b[i], o);
  endtask

  task automatic send(logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic recv(output logic [7:0] r);
    logic o;
    for (int i = 7; i >= 0; i--) begin
      xbit(1'b0, o);
      r[i] = o;
    end
  endtask

  task automatic cmd1(logic [7:0] op);
    fbegin(); send(op); fend();
  endtask

  task automatic cmd_addr(logic [7:0] op, logic [23:0] a);
    send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic rd_status(output logic [7:0] s);
    fbegin(); send(8'h05); recv(s); fend();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 so_oe", {31'd0, so_oe}, 0);
    check("R1 req_valid", {31'd0, req_valid}, 0);
    rd_status(s);
    check("R1 status", {24'd0, s}, 32'h00);
  endtask

  task automatic t_read();
    logic [7:0] r;
    fbegin(); cmd_addr(8'h03, 24'h000010);
    for (int k = 0; k < 3; k++) begin
      recv(r);
      check("R2 read byte", {24'd0, r}, {24'd0, memv(24'h10 + 24'(k))});
    end
    check("R2 so_oe while streaming", {31'd0, so_oe}, 1);
    fend();
  endtask

  task automatic t_fast();
    logic [7:0] r;
    fbegin(); cmd_addr(8'h0B, 24'h0000F0); send(8'h00);
    for (int k = 0; k < 2; k++) begin
      recv(r);
      check("R3 fast read byte", {24'd0, r}, {24'd0, memv(24'hF0 + 24'(k))});
    end
    fend();
  endtask

  task automatic t_latch();
    logic [7:0] a, b;
    cmd1(8'h06);
    fbegin(); send(8'h05); recv(a); recv(b); fend();
    check("R4 status wel", {24'd0, a}, 32'h02);
    check("R4 status repeats", {24'd0, b}, 32'h02);
    cmd1(8'h04);
    rd_status(a);
    check("R5 wrdi clears", {24'd0, a}, 32'h00);
  endtask

  task automatic t_no_wel();
    int c0;
    logic [7:0] s;
    c0 = n_acc;
    fbegin(); cmd_addr(8'h02, 24'h000040); send(8'h77); fend();
    fbegin(); cmd_addr(8'h20, 24'h001000); fend();
    fbegin(); send(8'h01); send(8'h80); fend();
    check("R5 no request without latch", n_acc - c0, 0);
    rd_status(s);
    check("R5 status untouched", {24'd0, s}, 32'h00);
  endtask

  task automatic t_prog();
    int c0;
    logic [7:0] s;
    c0 = n_acc;
    cmd1(8'h06);
    fbegin(); cmd_addr(8'h02, 24'h012345); send(8'h5A); fend();
    check("R7 one request", n_acc - c0, 1);
    check("R7 kind", {29'd0, acc_kind}, 0);
    check("R7 addr", {8'd0, acc_addr}, 32'h012345);
    check("R7 data", {24'd0, acc_data}, 32'h5A);
    rd_status(s);
    check("R11 latch cleared on accept", {24'd0, s}, 32'h00);
  endtask

  task automatic erase_one(logic [7:0] op, logic [2:0] kind, logic [23:0] exp_a, string tag);
    int c0;
    c0 = n_acc;
    cmd1(8'h06);
    fbegin();
    if (op == 8'hC7 || op == 8'h60) send(op);
    else cmd_addr(op, 24'h0ABCDE);
    fend();
    check(tag, n_acc - c0, 1);
    check(tag, {29'd0, acc_kind}, {29'd0, kind});
    check(tag, {8'd0, acc_addr}, {8'd0, exp_a});
  endtask

  task automatic t_erase();
    erase_one(8'h20, 3'd1, 24'h0AB000, "R6 4K erase");
    erase_one(8'h52, 3'd2, 24'h0A8000, "R6 32K erase");
    erase_one(8'hD8, 3'd3, 24'h0A0000, "R6 64K erase");
    erase_one(8'hC7, 3'd4, 24'h000000, "R6 chip erase C7");
    erase_one(8'h60, 3'd4, 24'h000000, "R6 chip erase 60");
  endtask

  task automatic t_cancel();
    int c0;
    logic [7:0] s;
    c0 = n_acc;
    cmd1(8'h06);
    fbegin(); send(8'h20); send(8'h0A); send(8'hBC); fend();
    fbegin(); send(8'h20); send(8'h0A); send(8'hBC); send_bits(8'hDE, 4); fend();
    fbegin(); send(8'hC7); send(8'h00); fend();
    fbegin(); send(8'hC7); send_bits(8'h00, 3); fend();
    check("R8 cancelled frames issue nothing", n_acc - c0, 0);
    rd_status(s);
    check("R8 latch kept", {24'd0, s}, 32'h02);
    cmd1(8'h04);
    fbegin(); send_bits(8'h06, 5); fend();
    fbegin(); send(8'h06); send_bits(8'h00, 3); fend();
    rd_status(s);
    check("R8 partial wren ignored", {24'd0, s}, 32'h00);
  endtask

  task automatic t_ids();
    logic [7:0] r;
    fbegin(); cmd_addr(8'h90, 24'h000001);
    recv(r); check("R9 id dev first", {24'd0, r}, 32'h91);
    recv(r); check("R9 id alternates", {24'd0, r}, 32'h5E);
    recv(r); check("R9 id alternates again", {24'd0, r}, 32'h91);
    fend();
    fbegin(); cmd_addr(8'hAB, 24'h000000);
    recv(r); check("R9 id mfg first", {24'd0, r}, 32'h5E);
    recv(r); check("R9 id then dev", {24'd0, r}, 32'h91);
    fend();
    fbegin(); send(8'h9F);
    recv(r); check("R9 jedec 0", {24'd0, r}, 32'h5E);
    recv(r); check("R9 jedec 1", {24'd0, r}, 32'h26);
    recv(r); check("R9 jedec 2", {24'd0, r}, 32'h82);
    recv(r); check("R9 jedec wrap", {24'd0, r}, 32'h5E);
    fend();
  endtask

  task automatic t_unknown();
    logic o;
    logic seen;
    seen = 1'b0;
    fbegin(); send(8'hFF);
    for (int i = 0; i < 16; i++) begin
      xbit(1'b0, o);
      if (so_oe) seen = 1'b1;
    end
    fend();
    check("R10 unknown opcode keeps so_oe low", {31'd0, seen}, 0);
  endtask

  task automatic t_backpressure();
    int c0;
    logic [7:0] s;
    c0 = n_acc;
    rdy = 1'b0;
    cmd1(8'h06);
    fbegin(); cmd_addr(8'h02, 24'h000100); send(8'h11); fend();
    check("R11 request waiting", {31'd0, req_valid}, 1);
    rd_status(s);
    check("R4 busy and latch", {24'd0, s}, 32'h03);
    fbegin(); cmd_addr(8'h02, 24'h000200); send(8'h22); fend();
    check("R11 held addr", {8'd0, req_addr}, 32'h000100);
    check("R11 held data", {24'd0, req_data}, 32'h11);
    wclk(1); rdy = 1'b1; wclk(6);
    check("R11 single accept", n_acc - c0, 1);
    check("R11 accepted first addr", {8'd0, acc_addr}, 32'h000100);
    rd_status(s);
    check("R11 latch cleared", {24'd0, s}, 32'h00);
    wclk(20);
    check("R11 second dropped", n_acc - c0, 1);
  endtask

  task automatic t_wrst();
    int c0;
    logic [7:0] s;
    c0 = n_acc;
    cmd1(8'h06);
    fbegin(); send(8'h01); send(8'hFC); fend();
    check("R12 one request", n_acc - c0, 1);
    check("R12 kind", {29'd0, acc_kind}, 5);
    check("R12 data", {24'd0, acc_data}, 32'hFC);
    rd_status(s);
    check("R12 status bits", {24'd0, s}, 32'hFC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; rdy = 1'b1;
    wclk(5); rst_n = 1'b1; wclk(4);
    t_reset();
    t_read();
    t_fast();
    t_latch();
    t_no_wel();
    t_prog();
    t_erase();
    t_cancel();
    t_ids();
    t_unknown();
    t_backpressure();
    t_wrst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule